// File: doc/BRIEF.md
# Q15 Dot Product with Toward-Zero Scaling

This block produces one output sample of a fixed-point linear predictor. It takes N signed 16-bit samples and N signed Q15 weights on two flat input buses. A start pulse captures both buses. The block then performs one 16x16 multiply-accumulate per cycle into a 32-bit accumulator. When the last lane is done, it scales the sum back to the sample range with a right shift of 15 bits and presents the result with a single-cycle valid pulse.

The scaling step matches integer division by 2^15, so it rounds toward zero. Before the arithmetic shift, a negative sum gets 2^15-1 added to it. A positive sum is shifted unchanged. The scaled value is clamped to the signed 16-bit range. The weights are expected to be real coefficients multiplied by 32768 and rounded to nearest before they reach the block.

Top module: `q15_dot_trunc`

## Requirements
- R1: While reset is asserted and after its release, `valid_o` is 0 and `result_o` is 0 until the first computation completes.
- R2: A start pulse captures `sample_i` and `weight_i`. Changes on these buses after the start cycle have no effect on the result. Lane i occupies bits [16i+15:16i] of each bus.
- R3: `valid_o` goes high exactly N+1 clock cycles after the edge at which start was sampled high, and stays high for one cycle only.
- R4: The block sums the N products sample_i*weight_i as signed values in a 32-bit accumulator. Overflow wraps modulo 2^32.
- R5: The 32-bit sum is scaled by an arithmetic right shift of 15 that rounds toward zero. A negative sum gets 32767 added before the shift, so a sum of -1 gives 0 and a sum of -32769 gives -1.
- R6: A negative sum whose low 15 bits are all zero is scaled with no adjustment. For example, -32768 gives -1 and -65536 gives -2.
- R7: A scaled value above 32767 is output as 32767, and a scaled value below -32768 is output as -32768.
- R8: A start pulse during a computation abandons that computation. No valid pulse is produced for it, and the next valid pulse carries the result of the new operands, N+1 cycles after the new start.
- R9: `result_o` holds its value in every cycle in which `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures operands, clears the accumulator and begins a computation |
| sample_i | input | N*16 | Signed 16-bit samples, lane i at bits [16i+15:16i] |
| weight_i | input | N*16 | Signed Q15 weights, lane i at bits [16i+15:16i] |
| result_o | output | 16 | Scaled and saturated dot product |
| valid_o | output | 1 | One-cycle pulse marking a new `result_o` |

## Verification
The timing assertion measures distance from the most recent start seen at the port. It therefore assumes that every start pulse is meant to restart the computation, even one that arrives while the previous result is still pending. The stimulus raises start for a single cycle, and it issues back-to-back starts only in the deliberate restart scenario. The assertions make no assumption about operand values. The sweep therefore walks full-scale extremes, including the sample and weight value -32768, whose products drive both the wraparound and the saturation corners.

// File: rtl/q15_dot_trunc.sv
module q15_dot_trunc #(
  parameter int N     = 16,
  parameter int DW    = 16,
  parameter int ACC_W = 32,
  parameter int SHIFT = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N*DW-1:0]      sample_i,
  input  logic [N*DW-1:0]      weight_i,
  output logic signed [DW-1:0] result_o,
  output logic                 valid_o
);

  localparam int CW = $clog2(N + 1);
  localparam logic signed [ACC_W-1:0] BIAS = ACC_W'((64'd1 << SHIFT) - 64'd1);
  localparam logic signed [ACC_W-1:0] HI   = ACC_W'((64'd1 << (DW - 1)) - 64'd1);
  localparam logic signed [ACC_W-1:0] LO   = -HI - ACC_W'(1);

  logic [N*DW-1:0]         x_q, w_q;
  logic signed [ACC_W-1:0] acc_q;
  logic [CW-1:0]           cnt_q;
  logic                    busy_q, fin_q;

  logic signed [2*DW-1:0]  prod;
  logic signed [ACC_W-1:0] biased, scaled;
  logic signed [DW-1:0]    clamped;

  assign prod    = $signed(x_q[DW-1:0]) * $signed(w_q[DW-1:0]);
  assign biased  = acc_q + (acc_q[ACC_W-1] ? BIAS : '0);
  assign scaled  = biased >>> SHIFT;
  assign clamped = (scaled > HI) ? HI[DW-1:0] :
                   (scaled < LO) ? LO[DW-1:0] : scaled[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q      <= '0;
      w_q      <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      fin_q    <= 1'b0;
      valid_o  <= 1'b0;
      result_o <= '0;
    end else if (start) begin
      x_q     <= sample_i;
      w_q     <= weight_i;
      acc_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      fin_q   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (busy_q) begin
        acc_q <= acc_q + ACC_W'(prod);
        x_q   <= x_q >> DW;
        w_q   <= w_q >> DW;
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(N - 1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
      if (fin_q) begin
        fin_q    <= 1'b0;
        valid_o  <= 1'b1;
        result_o <= clamped;
      end
    end
  end

endmodule

// File: rtl/q15_dot_trunc_chk.sv
module q15_dot_trunc_chk #(
  parameter int N  = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          valid_o,
  input logic [DW-1:0] result_o
);

  localparam int SW = $clog2(N + 3) + 1;
  localparam logic [SW-1:0] SMAX = '1;

  logic [SW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              since_q <= SMAX;
    else if (start)          since_q <= '0;
    else if (since_q != SMAX) since_q <= since_q + SW'(1);
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_valid_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> since_q == SW'(N + 1));

  assert_valid_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
    since_q == SW'(N + 1) |-> valid_o);

  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !valid_o);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));

endmodule

bind q15_dot_trunc q15_dot_trunc_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .valid_o(valid_o), .result_o(result_o)
);

// File: tb/q15_dot_trunc_tb.sv
module q15_dot_trunc_tb;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NL*16-1:0] sample_i = '0, weight_i = '0;
  logic signed [15:0] result_o;
  logic valid_o;

  int total = 0, bad = 0;
  shortint xs [NL];
  shortint ws [NL];

  always #4 clk = ~clk;

  q15_dot_trunc #(.N(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sample_i(sample_i), .weight_i(weight_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  function automatic int expect_val();
    int acc = 0;
    int q;
    for (int i = 0; i < NL; i++) acc += int'(xs[i]) * int'(ws[i]);
    if (acc < 0) acc += 32767;
    q = acc >>> 15;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic load();
    for (int i = 0; i < NL; i++) begin
      sample_i[16*i +: 16] = xs[i];
      weight_i[16*i +: 16] = ws[i];
    end
  endtask

  task automatic fire();
    @(negedge clk);
    load();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_check(input string req);
    int e;
    e = expect_val();
    fire();
    repeat (NL) @(negedge clk);
    @(negedge clk);
    check(req, int'(valid_o), 1);
    check(req, int'(result_o), e);
  endtask

  task automatic single(input shortint x0, input shortint w0, input string req);
    for (int i = 0; i < NL; i++) begin xs[i] = 0; ws[i] = 0; end
    xs[0] = x0; ws[0] = w0;
    run_check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    shortint vals [9] = '{-32768, -32767, -16384, -1, 0, 1, 2, 16384, 32767};
    int e, hold;
    repeat (3) @(negedge clk);
    check("R1", int'(valid_o), 0);
    check("R1", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(valid_o), 0);
    check("R1", int'(result_o), 0);

    // R3: exact pulse position and width
    for (int i = 0; i < NL; i++) begin xs[i] = shortint'(1000 * (i + 1)); ws[i] = 16384; end
    e = expect_val();
    fire();
    for (int j = 1; j <= NL; j++) begin
      @(negedge clk);
      check("R3", int'(valid_o), 0);
    end
    @(negedge clk);
    check("R3", int'(valid_o), 1);
    check("R4", int'(result_o), e);
    hold = result_o;
    @(negedge clk);
    check("R3", int'(valid_o), 0);
    repeat (3) @(negedge clk);
    check("R9", int'(result_o), hold);

    // R4, R5: sweep over extreme pairs spread across lanes
    foreach (vals[a]) foreach (vals[b]) begin
      for (int i = 0; i < NL; i++) begin
        xs[i] = shortint'(int'(vals[a]) + i * 37);
        ws[i] = shortint'(int'(vals[b]) - i * 101);
      end
      run_check("R4");
    end

    single(-1, 1, "R5");
    check("R5", int'(result_o), 0);
    single(-32769 / 3, 3, "R5");
    single(-3, 10923, "R5");
    single(-2, 16384, "R6");
    check("R6", int'(result_o), -1);
    single(-4, 16384, "R6");
    check("R6", int'(result_o), -2);
    single(-32768, -32768, "R7");
    check("R7", int'(result_o), 32767);
    for (int i = 0; i < NL; i++) begin xs[i] = 0; ws[i] = 0; end
    xs[0] = -32768; ws[0] = 32767; xs[1] = -32768; ws[1] = 32767;
    run_check("R7");
    check("R7", int'(result_o), -32768);
    for (int i = 0; i < NL; i++) begin xs[i] = -32768; ws[i] = -32768; end
    run_check("R4");
    check("R4", int'(result_o), 0);

    // R2: bus changes after capture are ignored
    for (int i = 0; i < NL; i++) begin xs[i] = shortint'(500 + i); ws[i] = shortint'(-20000 + i); end
    e = expect_val();
    fire();
    sample_i = '1;
    weight_i = {NL{16'h4000}};
    repeat (NL + 1) @(negedge clk);
    check("R2", int'(valid_o), 1);
    check("R2", int'(result_o), e);

    // R8: restart mid-computation
    for (int i = 0; i < NL; i++) begin xs[i] = 32767; ws[i] = 32767; end
    fire();
    @(negedge clk);
    for (int i = 0; i < NL; i++) begin xs[i] = shortint'(-7 * (i + 1)); ws[i] = 9000; end
    e = expect_val();
    fire();
    for (int j = 1; j <= NL; j++) begin
      @(negedge clk);
      check("R8", int'(valid_o), 0);
    end
    @(negedge clk);
    check("R8", int'(valid_o), 1);
    check("R8", int'(result_o), e);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule